// File: doc/BRIEF.md
# Quad SPI Command-Mode Word Engine

This block moves data between a host register port and a serial flash over SCLK, four chip selects and four data lines. Software sets a clock divider and per-select mode bits. It then writes a command word. Each accepted command shifts exactly one word of 1 to 128 bits. The word is either sent on one line or received on one, two or four lines. Words come from, or land in, a 128-bit data vector formed by four 32-bit data registers.

A frame counter keeps the chosen chip select asserted across several word commands. The select is released after the programmed number of words, or earlier by an invalidate command. Two status flags let software poll the engine: a busy flag and a word-complete flag.

Top module: `quad_spi_word_engine`

## Requirements
- R1: Clock register (word address 0): bit 31 enables SCLK, and bits 15:0 hold a divider d. Each bit slot lasts d+1 clock cycles, and d=0 behaves as d=1. While the enable bit is 0, SCLK stays at its idle level, and an accepted word waits with busy set until the enable bit is set.
- R2: Register word addresses are 0 clock, 1 device control, 2 command, 3 status (read-only), and 4 to 7 data registers 0 to 3. After reset every register reads 0, SCLK is low, every chip-select pin is high and no data line is driven.
- R3: Command fields are: select number in bits 29:28, word length minus one in bits 25:19, operation in bits 18:16 and frame length minus one in bits 11:0. The operation codes are 1 single read, 2 single write, 3 dual read, 4 invalidate and 7 quad read. A command with any other code is ignored and does not update the command register.
- R4: Status bit 0 is busy and bit 1 is word-complete. Word-complete is set on the cycle a word ends. It is cleared by a status read or by an accepted command. When a status read falls on the cycle a word ends, the flag ends up set.
- R5: The first word of a frame latches the select number and the frame length (1 to 4096 words). That select stays asserted between words and is released on the cycle the last word of the frame ends. The select field of later commands in the same frame is ignored.
- R6: An invalidate command accepted while idle ends the frame at once and releases the chip select.
- R7: While busy, writes to the command register and to the data registers are ignored.
- R8: Select n owns device-control byte n: bit 0 is clock polarity, bit 1 makes the select active-high, bit 2 is clock phase. In each bit slot SCLK is polarity XOR phase for the first half and the inverse for the second half. Outgoing data changes at slot start and incoming data is sampled in the second half.
- R9: A write drives only line 0, with output enable bit 0. It sends the low word-length bits of {data3,data2,data1,data0} most significant first, so a 128-bit word starts with data register 3.
- R10: A single read samples line 1. A dual read samples lines 1:0 with line 1 as the higher bit. A quad read samples lines 3:0 with line 3 highest. The received word lands right-aligned in {data3..data0} with all higher bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears word-complete on status) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| sclk | output | 1 | Serial clock |
| csel | output | 4 | Chip-select pins, level set by each select's polarity |
| dq_out | output | 4 | Data line output values |
| dq_oe | output | 4 | Data line output enables |
| dq_in | input | 4 | Data line input values |

## Verification
The word-complete flag can be set and cleared in the same cycle: a word ends on the same edge that a status read would clear the flag. The bench counts slots times (d+1) cycles from the command edge and times a status read to land on the completion edge. The value read in that cycle must still show busy and no completion. The next cycle must show the completion flag set, which confirms that the end of a word wins over the clearing read.

// File: rtl/qse_pkg.sv
// Shared constants and types for the quad SPI word engine.
// Assumes a 32-bit register port with word addressing.
package qse_pkg;
    typedef enum logic [2:0] {
        OP_RD1   = 3'd1,
        OP_WR1   = 3'd2,
        OP_RD2   = 3'd3,
        OP_INVAL = 3'd4,
        OP_RD4   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LN_ONE,
        LN_TWO,
        LN_FOUR
    } lanes_e;

    localparam logic [2:0] A_CLK  = 3'd0;
    localparam logic [2:0] A_DEV  = 3'd1;
    localparam logic [2:0] A_CMD  = 3'd2;
    localparam logic [2:0] A_STAT = 3'd3;
    localparam logic [2:0] A_DAT0 = 3'd4;

    localparam int F_CS_LSB = 28;
    localparam int F_WL_LSB = 19;
    localparam int F_OP_LSB = 16;
    localparam int F_FL_LSB = 0;
endpackage

// File: rtl/qse_clkdiv.sv
// Bit-slot timer: counts clk cycles inside one SCLK slot of (d+1) cycles.
// Assumes d=0 is treated as d=1, so each slot has two distinct halves.
module qse_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             sample,
    output logic             slot_end,
    output logic             second_half
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_c;
    logic [DIV_W-1:0] half_c;
    logic [DIV_W:0]   sum_c;

    // Derive the slot end count and the half-slot boundary.
    always_comb begin
        last_c = (div == '0) ? DIV_W'(1) : div;
        sum_c  = {1'b0, last_c} + 1'b1;
        half_c = sum_c[DIV_W:1];
    end

    assign sample      = run && (cnt_q == half_c);
    assign slot_end    = run && (cnt_q == last_c);
    assign second_half = (cnt_q >= half_c);

    // Slot counter: cleared on a new word, frozen while not running.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (restart)    cnt_q <= '0;
        else if (run)        cnt_q <= slot_end ? '0 : cnt_q + 1'b1;
    end

    assert_sample_in_second_half_R8: assert property (
        @(posedge clk) disable iff (!rst_n) sample |-> second_half);
endmodule

// File: rtl/qse_shifter.sv
// Half-duplex word shifter: sends on line 0 or samples 1, 2 or 4 lines.
// Assumes load only arrives while idle; tx_word is MSB-aligned at the top.
module qse_shifter
    import qse_pkg::*;
#(
    parameter int WORD_BITS = 128,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 rd_mode,
    input  lanes_e               lanes,
    input  logic [WORD_BITS-1:0] tx_word,
    input  logic [CNT_W-1:0]     slots,
    input  logic                 sample,
    input  logic                 slot_end,
    input  logic [3:0]           dq_in,
    output logic [3:0]           dq_out,
    output logic [3:0]           dq_oe,
    output logic                 done,
    output logic [WORD_BITS-1:0] word_d
);
    logic [WORD_BITS-1:0] sh_q;
    logic [WORD_BITS-1:0] sh_d;
    logic [CNT_W-1:0]     left_q;
    logic                 act_q;
    logic                 rd_q;
    lanes_e               ln_q;

    // Next shift register value: shift in on sample, shift out at slot end.
    always_comb begin
        sh_d = sh_q;
        if (act_q && rd_q && sample) begin
            case (ln_q)
                LN_TWO:  sh_d = {sh_q[WORD_BITS-3:0], dq_in[1:0]};
                LN_FOUR: sh_d = {sh_q[WORD_BITS-5:0], dq_in};
                default: sh_d = {sh_q[WORD_BITS-2:0], dq_in[1]};
            endcase
        end
        if (act_q && !rd_q && slot_end)
            sh_d = {sh_q[WORD_BITS-2:0], 1'b0};
    end

    assign done   = act_q && slot_end && (left_q == CNT_W'(1));
    assign word_d = sh_d;
    assign dq_out = {3'b000, (act_q && !rd_q) ? sh_q[WORD_BITS-1] : 1'b0};
    assign dq_oe  = {3'b000, act_q && !rd_q};

    // Word state: load a new word, then count slots down to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            act_q  <= 1'b0;
            rd_q   <= 1'b0;
            ln_q   <= LN_ONE;
        end else if (load) begin
            sh_q   <= rd_mode ? '0 : tx_word;
            left_q <= slots;
            act_q  <= 1'b1;
            rd_q   <= rd_mode;
            ln_q   <= lanes;
        end else begin
            sh_q <= sh_d;
            if (act_q && slot_end) left_q <= left_q - 1'b1;
            if (done)              act_q  <= 1'b0;
        end
    end

    assert_slot_count_nonzero_R3: assert property (
        @(posedge clk) disable iff (!rst_n) load |=> (left_q != '0));
endmodule

// File: rtl/quad_spi_word_engine.sv
// Quad SPI command-mode word engine: register port, frame tracking, status.
// Assumes at most four selects (one device-control byte each) and 32-bit data registers.
module quad_spi_word_engine
    import qse_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int DATA_REGS = 4,
    parameter int DIV_W     = 16,
    parameter int FLEN_W    = 12,
    localparam int ADDR_W    = $clog2(4 + DATA_REGS),
    localparam int WORD_BITS = 32 * DATA_REGS,
    localparam int LEN_W     = $clog2(WORD_BITS) + 1,
    localparam int CS_W      = $clog2(NUM_CS),
    localparam int DI_W      = $clog2(DATA_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic [NUM_CS-1:0] csel,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic [3:0]        dq_in
);
    logic                 clk_en_q;
    logic [DIV_W-1:0]     div_q;
    logic [31:0]          dev_q;
    logic [31:0]          cmd_q;
    logic [31:0]          dat_q [DATA_REGS];
    logic                 busy_q;
    logic                 wc_q;
    logic                 frm_q;
    logic [CS_W-1:0]      fcs_q;
    logic [FLEN_W:0]      flen_q;
    logic [FLEN_W:0]      wcnt_q;

    logic [2:0]           op_c;
    logic                 op_ok_c;
    logic                 cmd_wr, accept, start, inval, stat_rd, dat_wr;
    logic [LEN_W-1:0]     wlen_c, slots_c, pad_c;
    lanes_e               lanes_c;
    logic [WORD_BITS-1:0] dat_vec, tx_c, word_d;
    logic [ADDR_W-1:0]    di_c;
    logic [7:0]           mode_c;
    logic                 sample, slot_end, second_half, sh_done;

    // Decode a command write and its operation code.
    always_comb begin
        op_c = reg_wdata[F_OP_LSB +: 3];
        case (op_c)
            OP_RD1, OP_WR1, OP_RD2, OP_INVAL, OP_RD4: op_ok_c = 1'b1;
            default:                                  op_ok_c = 1'b0;
        endcase
    end

    assign cmd_wr  = reg_wr && (reg_addr == ADDR_W'(A_CMD));
    assign accept  = cmd_wr && !busy_q && op_ok_c;
    assign start   = accept && (op_c != OP_INVAL);
    assign inval   = accept && (op_c == OP_INVAL);
    assign stat_rd = reg_rd && (reg_addr == ADDR_W'(A_STAT));
    assign di_c    = reg_addr - ADDR_W'(A_DAT0);
    assign dat_wr  = reg_wr && (reg_addr >= ADDR_W'(A_DAT0)) && !busy_q;

    // Word length, lane count, slot count and transmit alignment.
    always_comb begin
        wlen_c = LEN_W'(reg_wdata[F_WL_LSB +: LEN_W-1]) + 1'b1;
        case (op_c)
            OP_RD2:  lanes_c = LN_TWO;
            OP_RD4:  lanes_c = LN_FOUR;
            default: lanes_c = LN_ONE;
        endcase
        case (lanes_c)
            LN_TWO:  slots_c = (wlen_c + LEN_W'(1)) >> 1;
            LN_FOUR: slots_c = (wlen_c + LEN_W'(3)) >> 2;
            default: slots_c = wlen_c;
        endcase
        pad_c = LEN_W'(WORD_BITS) - wlen_c;
        for (int i = 0; i < DATA_REGS; i++) dat_vec[i*32 +: 32] = dat_q[i];
        tx_c = dat_vec << pad_c;
    end

    // Mode bits of the latched select and the SCLK waveform.
    assign mode_c = dev_q[{fcs_q, 3'b000} +: 8];
    assign sclk   = (busy_q && clk_en_q) ? (mode_c[0] ^ mode_c[2] ^ second_half) : mode_c[0];

    // Chip-select pins: asserted level follows each select's polarity bit.
    generate
        for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
            assign csel[g] = ~((frm_q && (fcs_q == CS_W'(g))) ^ dev_q[8*g + 1]);
        end
    endgenerate

    qse_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
        .clk(clk), .rst_n(rst_n), .run(busy_q && clk_en_q), .restart(start),
        .div(div_q), .sample(sample), .slot_end(slot_end), .second_half(second_half)
    );

    qse_shifter #(.WORD_BITS(WORD_BITS), .CNT_W(LEN_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .load(start), .rd_mode(op_c != OP_WR1),
        .lanes(lanes_c), .tx_word(tx_c), .slots(slots_c), .sample(sample),
        .slot_end(slot_end), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .done(sh_done), .word_d(word_d)
    );

    // Read mux for the register port.
    always_comb begin
        case (reg_addr)
            ADDR_W'(A_CLK):  reg_rdata = {clk_en_q, {(31-DIV_W){1'b0}}, div_q};
            ADDR_W'(A_DEV):  reg_rdata = dev_q;
            ADDR_W'(A_CMD):  reg_rdata = cmd_q;
            ADDR_W'(A_STAT): reg_rdata = {30'b0, wc_q, busy_q};
            default:         reg_rdata = dat_q[di_c[DI_W-1:0]];
        endcase
    end

    // Configuration registers, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            div_q    <= '0;
            dev_q    <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CLK)) begin
                clk_en_q <= reg_wdata[31];
                div_q    <= reg_wdata[DIV_W-1:0];
            end
            if (reg_addr == ADDR_W'(A_DEV)) dev_q <= reg_wdata;
        end
    end

    // Command register holds the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= reg_wdata;
    end

    // Data registers: host writes while idle, received word on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DATA_REGS; i++) dat_q[i] <= '0;
        end else if (sh_done && (cmd_q[F_OP_LSB +: 3] != OP_WR1)) begin
            for (int i = 0; i < DATA_REGS; i++) dat_q[i] <= word_d[i*32 +: 32];
        end else if (dat_wr) begin
            dat_q[di_c[DI_W-1:0]] <= reg_wdata;
        end
    end

    // Busy and word-complete flags; completion wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            wc_q   <= 1'b0;
        end else begin
            if (start)        busy_q <= 1'b1;
            else if (sh_done) busy_q <= 1'b0;
            if (accept)       wc_q <= 1'b0;
            else if (sh_done) wc_q <= 1'b1;
            else if (stat_rd) wc_q <= 1'b0;
        end
    end

    // Frame tracking: latch select and length, count finished words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q  <= 1'b0;
            fcs_q  <= '0;
            flen_q <= '0;
            wcnt_q <= '0;
        end else if (inval) begin
            frm_q <= 1'b0;
        end else if (start && !frm_q) begin
            frm_q  <= 1'b1;
            fcs_q  <= reg_wdata[F_CS_LSB +: CS_W];
            flen_q <= {1'b0, reg_wdata[F_FL_LSB +: FLEN_W]} + 1'b1;
            wcnt_q <= '0;
        end else if (sh_done) begin
            if (wcnt_q + 1'b1 == flen_q) frm_q  <= 1'b0;
            else                         wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assert_busy_in_frame_R5: assert property (
        @(posedge clk) disable iff (!rst_n) busy_q |-> frm_q);
    assert_frame_bound_R5: assert property (
        @(posedge clk) disable iff (!rst_n) frm_q |-> (wcnt_q < flen_q));
    assert_done_while_busy_R4: assert property (
        @(posedge clk) disable iff (!rst_n) sh_done |-> busy_q);
    assert_wc_after_word_R4: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(wc_q) |-> $fell(busy_q));
    assert_busy_cmd_ignored_R7: assert property (
        @(posedge clk) disable iff (!rst_n) (busy_q && cmd_wr) |=> $stable(cmd_q));
endmodule

// File: tb/quad_spi_word_engine_tb_top.sv
module quad_spi_word_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sclk;
    logic [3:0]  csel, dq_out, dq_oe, dq_in;

    int n_chk = 0, n_err = 0;
    int cyc = 0, ncap = 0, last_rise = 0, period = 0, dev_lanes = 1;
    logic [127:0] mosi = '0, dev_pat = '0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    quad_spi_word_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .csel(csel),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    // Flash model: capture line 0 on rising SCLK, present read data, shift on falling SCLK.
    always @(posedge sclk) begin
        if (dq_oe[0]) begin mosi = {mosi[126:0], dq_out[0]}; ncap++; end
        period = cyc - last_rise;
        last_rise = cyc;
    end
    always @(negedge sclk) dev_pat = dev_pat << dev_lanes;
    assign dq_in = (dev_lanes == 4) ? dev_pat[127:124] :
                   (dev_lanes == 2) ? {2'b00, dev_pat[127:126]} : {2'b00, dev_pat[127], 1'b0};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input int cs, input int wlen, input int op, input int flen);
        return {2'b00, 2'(cs), 2'b00, 7'(wlen - 1), 3'(op), 4'b0000, 12'(flen - 1)};
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle(output logic [31:0] s);
        int guard = 0;
        do begin rd_reg(3'd3, s); guard++; end while (s[0] && guard < 5000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R2 csel idle", 128'(csel), 128'hF);
        chk("R2 sclk idle", 128'(sclk), 128'h0);
        chk("R2 no drive", 128'(dq_oe), 128'h0);
        rd_reg(3'd3, v); chk("R2 status reset", 128'(v), 128'h0);
        rd_reg(3'd0, v); chk("R2 clock reg reset", 128'(v), 128'h0);
        rd_reg(3'd4, v); chk("R2 data0 reset", 128'(v), 128'h0);
    endtask

    task automatic t_write();
        logic [31:0] s;
        wr_reg(3'd0, 32'h8000_0003);
        wr_reg(3'd4, 32'h0000_00A5);
        mosi = '0; ncap = 0;
        wr_reg(3'd2, cmd(1, 8, 2, 1));
        @(negedge clk);
        chk("R5 select 1 asserted", 128'(csel), 128'hD);
        chk("R9 only line 0 driven", 128'(dq_oe), 128'h1);
        wait_idle(s);
        chk("R4 complete flag", 128'(s), 128'h2);
        chk("R9 bit count", 128'(ncap), 128'd8);
        chk("R9 sent byte", 128'(mosi[7:0]), 128'hA5);
        chk("R1 period d=3", 128'(period), 128'd4);
        chk("R5 released after frame", 128'(csel), 128'hF);
        rd_reg(3'd3, s); chk("R4 cleared by read", 128'(s), 128'h0);
    endtask

    task automatic t_long();
        logic [31:0] s;
        wr_reg(3'd0, 32'h8000_0000);
        wr_reg(3'd4, 32'h0123_4567); wr_reg(3'd5, 32'h89AB_CDEF);
        wr_reg(3'd6, 32'h1357_9BDF); wr_reg(3'd7, 32'h2468_ACE0);
        mosi = '0; ncap = 0;
        wr_reg(3'd2, cmd(0, 128, 2, 1));
        wait_idle(s);
        chk("R9 128-bit count", 128'(ncap), 128'd128);
        chk("R9 128-bit order", mosi, {32'h2468_ACE0, 32'h1357_9BDF, 32'h89AB_CDEF, 32'h0123_4567});
        chk("R1 d=0 acts as 1", 128'(period), 128'd2);
    endtask

    task automatic t_reads();
        logic [31:0] s, v;
        wr_reg(3'd0, 32'h8000_0001);
        for (int i = 4; i < 8; i++) wr_reg(3'(i), 32'hFFFF_FFFF);
        dev_lanes = 1; dev_pat = {8'h3C, 120'b0};
        wr_reg(3'd2, cmd(0, 8, 1, 1)); wait_idle(s);
        rd_reg(3'd4, v); chk("R10 single read", 128'(v), 128'h3C);
        rd_reg(3'd5, v); chk("R10 upper cleared d1", 128'(v), 128'h0);
        rd_reg(3'd7, v); chk("R10 upper cleared d3", 128'(v), 128'h0);
        dev_lanes = 2; dev_pat = {16'hB4E1, 112'b0};
        wr_reg(3'd2, cmd(0, 16, 3, 1)); wait_idle(s);
        rd_reg(3'd4, v); chk("R10 dual read", 128'(v), 128'hB4E1);
        dev_lanes = 4; dev_pat = {32'hDEAD_BEEF, 96'b0};
        wr_reg(3'd2, cmd(0, 32, 7, 1)); wait_idle(s);
        rd_reg(3'd4, v); chk("R10 quad read", 128'(v), 128'hDEAD_BEEF);
        dev_lanes = 1; dev_pat = '0;
    endtask

    task automatic t_frame();
        logic [31:0] s;
        wr_reg(3'd4, 32'h11);
        wr_reg(3'd2, cmd(2, 8, 2, 3)); wait_idle(s);
        chk("R5 held after word 1", 128'(csel), 128'hB);
        wr_reg(3'd2, cmd(0, 8, 2, 3)); wait_idle(s);
        chk("R5 select field ignored", 128'(csel), 128'hB);
        wr_reg(3'd2, cmd(2, 8, 2, 3)); wait_idle(s);
        chk("R5 released after word 3", 128'(csel), 128'hF);
    endtask

    task automatic t_inval();
        logic [31:0] s;
        wr_reg(3'd2, cmd(1, 8, 2, 10)); wait_idle(s);
        chk("R6 frame open", 128'(csel), 128'hD);
        wr_reg(3'd2, cmd(0, 1, 4, 1));
        chk("R6 invalidate releases", 128'(csel), 128'hF);
        rd_reg(3'd3, s); chk("R4 flag clear after invalidate", 128'(s), 128'h0);
    endtask

    task automatic t_bad();
        logic [31:0] v;
        wr_reg(3'd2, cmd(1, 8, 5, 1));
        chk("R3 bad code no select", 128'(csel), 128'hF);
        rd_reg(3'd3, v); chk("R3 bad code not busy", 128'(v), 128'h0);
        rd_reg(3'd2, v); chk("R3 command reg kept", 128'(v), 128'(cmd(0, 1, 4, 1)));
    endtask

    task automatic t_busy();
        logic [31:0] s, v;
        wr_reg(3'd0, 32'h8000_0003);
        wr_reg(3'd4, 32'h5A);
        mosi = '0; ncap = 0;
        wr_reg(3'd2, cmd(1, 16, 2, 1));
        wr_reg(3'd2, cmd(2, 8, 1, 1));
        wr_reg(3'd4, 32'h1234);
        rd_reg(3'd3, s); chk("R7 still busy", 128'(s), 128'h1);
        wait_idle(s);
        rd_reg(3'd4, v); chk("R7 data write ignored", 128'(v), 128'h5A);
        rd_reg(3'd2, v); chk("R7 command ignored", 128'(v), 128'(cmd(1, 16, 2, 1)));
        chk("R7 one word sent", 128'(ncap), 128'd16);
        chk("R9 16-bit word", 128'(mosi[15:0]), 128'h005A);
        chk("R7 select released", 128'(csel), 128'hF);
    endtask

    task automatic t_same();
        logic [31:0] s;
        wr_reg(3'd2, cmd(1, 8, 2, 1));
        repeat (31) @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd3; #1 s = reg_rdata;
        chk("R4 busy before end edge", 128'(s), 128'h1);
        @(negedge clk); reg_rd = 1'b0; #1 s = reg_rdata;
        chk("R4 completion beats read clear", 128'(s), 128'h2);
        rd_reg(3'd3, s);
    endtask

    task automatic t_gate();
        logic [31:0] s;
        wr_reg(3'd0, 32'h0000_0003);
        ncap = 0;
        wr_reg(3'd2, cmd(1, 8, 2, 1));
        repeat (40) @(negedge clk);
        chk("R1 gated sclk idle", 128'(sclk), 128'h0);
        chk("R1 gated no bits", 128'(ncap), 128'd0);
        rd_reg(3'd3, s); chk("R1 gated stays busy", 128'(s), 128'h1);
        wr_reg(3'd0, 32'h8000_0003);
        wait_idle(s);
        chk("R1 resumes after enable", 128'(ncap), 128'd8);
    endtask

    task automatic t_mode();
        logic [31:0] s;
        wr_reg(3'd1, 32'h0700_0000);
        wr_reg(3'd2, cmd(3, 8, 2, 1));
        chk("R8 first half pol^pha", 128'(sclk), 128'h0);
        chk("R8 active-high select", 128'(csel[3]), 128'h1);
        repeat (2) @(negedge clk);
        chk("R8 second half inverted", 128'(sclk), 128'h1);
        wait_idle(s);
        chk("R8 idle at polarity 1", 128'(sclk), 128'h1);
        chk("R8 active-high idle low", 128'(csel), 128'h7);
        wr_reg(3'd1, 32'h0400_0000);
        wr_reg(3'd2, cmd(3, 8, 2, 1));
        chk("R8 phase only first half", 128'(sclk), 128'h1);
        wait_idle(s);
        chk("R8 idle at polarity 0", 128'(sclk), 128'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_long();
        t_reads();
        t_frame();
        t_inval();
        t_bad();
        t_busy();
        t_same();
        t_gate();
        t_mode();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule